// File: doc/BRIEF.md
# Free-Running Compare Match Timer

This block is a memory-mapped timer that a processor uses to schedule one-shot events. A counter of parameterized width (32 bits by default) advances once per prescaled tick while the module is enabled. Software arms an event by writing a compare value. When the counter steps onto that value, a sticky event flag is raised. The flag drives a level interrupt for as long as the interrupt enable is set, until software clears the flag by writing a one to it.

Matching uses exact equality against a counter that wraps freely. Software can therefore park the next event almost a whole counter period away by writing the current count minus a small offset. A restart mode returns the counter to zero on the tick after it reaches the compare value, which turns the block into a periodic divider. The register bus is a single-cycle bus: writes are taken at the clock edge while the write enable is high, and reads are combinational from the address.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0, the count reads 0 and the interrupt output is low.
- R2: The control register at offset 0x00 stores bit 0 (run), bit 3 (keep running in wait mode), bit 6 (count from the bus clock) and bit 9 (free-run). All four bits read back as written, and every other bit reads 0.
- R3: While run is low, the counter and the prescale divider are forced to 0 from the cycle after run falls, and they stay at 0.
- R4: A prescaler value N at offset 0x04 gives one counter increment every N+1 clock cycles while running. The first increment comes N+1 cycles after run is set, so N = 0 counts on every clock.
- R5: In free-run mode the counter keeps counting through a compare match and wraps from all ones to 0.
- R6: In restart mode (bit 9 low), the counter goes to 0 on the first tick after it holds the compare value.
- R7: The compare value at offset 0x10 reads back as written. The count reads at offset 0x24, and writes to offset 0x24 have no effect.
- R8: Status bit 0 at offset 0x08 is set on the tick on which the counter takes a value equal to the compare value, and it stays set until it is cleared.
- R9: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R10: The interrupt output is high exactly while status bit 0 and interrupt-enable bit 0 (offset 0x0C) are both 1.
- R11: If a match and a write that clears the status land in the same cycle, the flag stays set.
- R12: A compare value a few counts below the current count does not raise the flag until the counter has wrapped and reached that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The compare path is tested with a free-running count hitting a small compare value, with the same value in restart mode, and with a compare value parked just below zero. Together these separate "keep counting", "restart at zero" and "fire only after a full wrap". Runs with prescaler values 0 and 3 separate a per-clock tick from a divided tick, and they show whether the divider's first tick comes at the right cycle. A clear write timed onto the exact match edge shows that the match wins. Clear writes of 0 and of 1 separate write-one-to-clear from a plain store.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PRESC = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CMP   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h24;

    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_WAIT = 3;
    localparam int unsigned CB_CSRC = 6;
    localparam int unsigned CB_FREE = 9;

    typedef struct packed {
        logic free_run;
        logic clk_src;
        logic wait_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/evt_timer_prescale.sv
module evt_timer_prescale #(
    parameter int unsigned PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tick_o
);

    typedef struct packed {
        logic [PRESC_W-1:0] div;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = run_i && (s_q.div >= presc_i);
        if (!run_i) begin
            s_d.div = '0;
        end else if (tick_o) begin
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: divider held at zero while stopped
    p_div_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (s_q.div == '0));

    // R4: a tick restarts the divide window
    p_div_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (s_q.div == '0));

endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             free_run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic             at_cmp;
    logic [CNT_W-1:0] step;

    always_comb begin
        s_d     = s_q;
        at_cmp  = (s_q.cnt == cmp_i);
        step    = (!free_run_i && at_cmp) ? '0 : s_q.cnt + 1'b1;
        match_o = 1'b0;
        if (!run_i) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            s_d.cnt = step;
            match_o = (step == cmp_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o = s_q.cnt;

    // R3: count cleared the cycle after run is low
    p_cnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (count_o == '0));

    // R5: free-run steps by one per tick, wrapping naturally
    p_free_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && free_run_i) |=> (count_o == $past(count_o) + 1'b1));

    // R6: restart mode returns to zero after holding the compare value
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !free_run_i && count_o == cmp_i) |=> (count_o == '0));

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int unsigned PRESC_W = 16,
    parameter int unsigned CNT_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              match_i,
    input  logic [CNT_W-1:0]  count_i,
    output ctrl_t             ctrl_o,
    output logic [PRESC_W-1:0] presc_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              stat_o,
    output logic              ien_o,
    output logic [BUS_W-1:0]  rdata_o
);

    typedef struct packed {
        ctrl_t              ctrl;
        logic [PRESC_W-1:0] presc;
        logic [CNT_W-1:0]   cmp;
        logic               stat;
        logic               ien;
    } reg_state_t;

    reg_state_t r_d, r_q;
    logic wr_ctrl, wr_presc, wr_stat, wr_ien, wr_cmp, clr_stat;

    always_comb begin
        r_d      = r_q;
        wr_ctrl  = we_i && (addr_i == OFS_CTRL);
        wr_presc = we_i && (addr_i == OFS_PRESC);
        wr_stat  = we_i && (addr_i == OFS_STAT);
        wr_ien   = we_i && (addr_i == OFS_IEN);
        wr_cmp   = we_i && (addr_i == OFS_CMP);
        clr_stat = wr_stat && wdata_i[0];
        if (wr_ctrl) begin
            r_d.ctrl.run      = wdata_i[CB_RUN];
            r_d.ctrl.wait_en  = wdata_i[CB_WAIT];
            r_d.ctrl.clk_src  = wdata_i[CB_CSRC];
            r_d.ctrl.free_run = wdata_i[CB_FREE];
        end
        if (wr_presc) r_d.presc = wdata_i[PRESC_W-1:0];
        if (wr_cmp)   r_d.cmp   = wdata_i[CNT_W-1:0];
        if (wr_ien)   r_d.ien   = wdata_i[0];
        // a match in the same cycle outranks a clear
        r_d.stat = (r_q.stat && !clr_stat) || match_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_CTRL: begin
                rdata_o[CB_RUN]  = r_q.ctrl.run;
                rdata_o[CB_WAIT] = r_q.ctrl.wait_en;
                rdata_o[CB_CSRC] = r_q.ctrl.clk_src;
                rdata_o[CB_FREE] = r_q.ctrl.free_run;
            end
            OFS_PRESC: rdata_o[PRESC_W-1:0] = r_q.presc;
            OFS_STAT:  rdata_o[0]           = r_q.stat;
            OFS_IEN:   rdata_o[0]           = r_q.ien;
            OFS_CMP:   rdata_o[CNT_W-1:0]   = r_q.cmp;
            OFS_CNT:   rdata_o[CNT_W-1:0]   = count_i;
            default:   rdata_o              = '0;
        endcase
    end

    assign ctrl_o  = r_q.ctrl;
    assign presc_o = r_q.presc;
    assign cmp_o   = r_q.cmp;
    assign stat_o  = r_q.stat;
    assign ien_o   = r_q.ien;

    // R8: flag is sticky unless a one is written to it
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !(we_i && addr_i == OFS_STAT && wdata_i[0])) |=> stat_o);

    // R11: a match always leaves the flag set, even against a clear
    p_match_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> stat_o);

    // R9: a write of zero to status never clears it
    p_w0_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && we_i && addr_i == OFS_STAT && !wdata_i[0]) |=> stat_o);

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int unsigned PRESC_W = 16,
    parameter int unsigned CNT_W   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);

    ctrl_t              ctrl;
    logic [PRESC_W-1:0] presc;
    logic [CNT_W-1:0]   cmp;
    logic [CNT_W-1:0]   count;
    logic               stat;
    logic               ien;
    logic               tick;
    logic               match;

    evt_timer_regs #(
        .PRESC_W (PRESC_W),
        .CNT_W   (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .we_i    (bus_we),
        .wdata_i (bus_wdata),
        .match_i (match),
        .count_i (count),
        .ctrl_o  (ctrl),
        .presc_o (presc),
        .cmp_o   (cmp),
        .stat_o  (stat),
        .ien_o   (ien),
        .rdata_o (bus_rdata)
    );

    evt_timer_prescale #(
        .PRESC_W (PRESC_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ctrl.run),
        .presc_i (presc),
        .tick_o  (tick)
    );

    evt_timer_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctrl.run),
        .free_run_i (ctrl.free_run),
        .tick_i     (tick),
        .cmp_i      (cmp),
        .count_o    (count),
        .match_o    (match)
    );

    assign irq_o = stat && ien;

    // R8: a newly raised flag means the count sits on the compare value
    p_flag_eq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat) && $stable(cmp)) |-> (count == cmp));

    // R10: a raised interrupt holds until the flag or the enable is cleared
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(bus_we && (bus_addr == OFS_STAT || bus_addr == OFS_IEN))) |=> irq_o);

    // R4: no tick arrives while stopped
    p_no_tick_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !tick);

endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;

    localparam int unsigned CW = 16;
    localparam logic [7:0] A_CTRL = 8'h00, A_PRE = 8'h04, A_STAT = 8'h08,
                           A_IEN = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;
    localparam logic [31:0] C_FREE = 32'h201, C_RESTART = 32'h001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    evt_timer #(.PRESC_W(16), .CNT_W(CW)) u_evt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    // stop, clear the flag, then start with the given control word
    task automatic restart_timer(input logic [31:0] c);
        bus_wr(A_CTRL, 32'h0);
        idle(1);
        bus_wr(A_STAT, 32'h1);
        bus_wr(A_CTRL, c);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", A_CTRL, 0);
        rd_chk("R1 presc", A_PRE, 0);
        rd_chk("R1 stat", A_STAT, 0);
        rd_chk("R1 ien", A_IEN, 0);
        rd_chk("R1 cmp", A_CMP, 0);
        rd_chk("R1 count", A_CNT, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);
        idle(4);
        rd_chk("R3 count idle after reset", A_CNT, 0);
    endtask

    task automatic t_ctrl_bits;
        bus_wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl all ones", A_CTRL, 32'h249);
        bus_wr(A_CTRL, 32'h248);
        rd_chk("R2 ctrl no run", A_CTRL, 32'h248);
        bus_wr(A_CTRL, 32'h0);
    endtask

    task automatic t_prescale;
        bus_wr(A_PRE, 32'd3);
        bus_wr(A_CMP, 32'hFFF0);
        rd_chk("R7 cmp readback", A_CMP, 32'hFFF0);
        rd_chk("R4 presc readback", A_PRE, 32'd3);
        restart_timer(C_FREE);
        idle(7);
        rd_chk("R4 count after 7 clocks", A_CNT, 1);
        idle(1);
        rd_chk("R4 count after 8 clocks", A_CNT, 2);
        bus_wr(A_PRE, 32'd0);
    endtask

    task automatic t_disable;
        bus_wr(A_CTRL, 32'h0);
        idle(1);
        rd_chk("R3 count cleared", A_CNT, 0);
        idle(5);
        rd_chk("R3 count held", A_CNT, 0);
        bus_wr(A_CNT, 32'h55);
        rd_chk("R7 count write ignored", A_CNT, 0);
    endtask

    task automatic t_free_match;
        bus_wr(A_IEN, 32'h0);
        bus_wr(A_CMP, 32'd5);
        restart_timer(C_FREE);
        idle(4);
        rd_chk("R8 count before match", A_CNT, 4);
        rd_chk("R8 no flag before match", A_STAT, 0);
        idle(1);
        rd_chk("R8 count at match", A_CNT, 5);
        rd_chk("R8 flag at match", A_STAT, 1);
        chk("R10 irq masked", {31'b0, irq_o}, 0);
        idle(3);
        rd_chk("R5 free-run passes match", A_CNT, 8);
        rd_chk("R8 flag sticky", A_STAT, 1);
        bus_wr(A_IEN, 32'h1);
        chk("R10 irq when enabled", {31'b0, irq_o}, 1);
        bus_wr(A_STAT, 32'h0);
        rd_chk("R9 write zero keeps flag", A_STAT, 1);
        bus_wr(A_STAT, 32'h1);
        rd_chk("R9 write one clears flag", A_STAT, 0);
        chk("R10 irq drops with flag", {31'b0, irq_o}, 0);
        bus_wr(A_IEN, 32'h0);
    endtask

    task automatic t_restart;
        bus_wr(A_CMP, 32'd3);
        restart_timer(C_RESTART);
        idle(3);
        rd_chk("R6 count reaches compare", A_CNT, 3);
        rd_chk("R6 flag at compare", A_STAT, 1);
        idle(1);
        rd_chk("R6 restart to zero", A_CNT, 0);
        idle(3);
        rd_chk("R6 second pass", A_CNT, 3);
    endtask

    task automatic t_same_cycle;
        bus_wr(A_CMP, 32'd6);
        restart_timer(C_FREE);
        idle(5);
        bus_wr(A_STAT, 32'h1);
        rd_chk("R11 match beats clear", A_STAT, 1);
        bus_wr(A_STAT, 32'h1);
        rd_chk("R11 later clear works", A_STAT, 0);
    endtask

    task automatic t_park_wrap;
        bus_wr(A_CMP, 32'hFFFD);
        restart_timer(C_FREE);
        idle(1000);
        rd_chk("R12 parked compare quiet", A_STAT, 0);
        idle(65532 - 1000);
        rd_chk("R12 count just before", A_CNT, 32'hFFFC);
        rd_chk("R12 still quiet", A_STAT, 0);
        idle(1);
        rd_chk("R12 fires after wrap distance", A_STAT, 1);
        idle(3);
        rd_chk("R5 wrap to zero", A_CNT, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_ctrl_bits();
        t_prescale();
        t_disable();
        t_free_match();
        t_restart();
        t_same_cycle();
        t_park_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule